// File: doc/BRIEF.md
# Auto-Increment SRAM Address Sequencer

This block sits between a host that has a byte-wide port and an asynchronous static RAM. The block keeps the RAM address in its own counter, so the host does not send an address for every byte. In a block transfer the host only lowers its select line once per byte. The counter then steps forward when that select line is released. The host can reset the counter to the bottom of memory with a clear request. It can also set any start address by writing a low byte and then a high byte. Those two bytes go to register pages, which the block picks out by decoding the host's upper page lines.

The host select line is asynchronous to the block clock. A two-stage synchroniser brings it into the clock domain, and an edge detector turns each release of the line into exactly one step. The RAM chip select and write enable are formed from the synchronised select. Because of this, the counter can only change while the RAM is deselected, and a write never has a moving address under it.

The host must keep its page, write flag and data stable from the falling edge of select until four clock cycles after the rising edge. Select must stay low for at least three clock cycles and high for at least three clock cycles.

Top module: `sram_addr_seq`

## Requirements
- R1: After reset the address output is 0x0000, and both the RAM chip select and the write enable are inactive (high).
- R2: Each select pulse on a RAM page (page code 0 or 1) advances the address by exactly one. The step is taken only after select rises, and the new address appears within four clock cycles of that rise.
- R3: The address wraps from 0xFFFF to 0x0000 on a step, and no other effect follows.
- R4: A clear request (hostClr high for one cycle) sets the address to 0x0000. If a RAM access is in progress, the clear waits until select is released. The clear then replaces the step or the high-byte load of that access.
- R5: A write to page code 3 stores the host data byte as the pending low address byte. It leaves the current address unchanged and does not select the RAM.
- R6: A write to page code 2 loads the address with the host data as the high byte and the pending low byte as the low byte. The next RAM access uses that address.
- R7: A read (hostWrite low) of page code 2 or 3 changes neither the address nor the pending low byte.
- R8: The RAM chip select is low only while the synchronised host select is low and the page is a RAM page. It is never low for a register page.
- R9: Write enable is low only while chip select is low and the access is a write. It is never low during a read access or while a step, load or clear is applied.
- R10: The address never changes while chip select is low. Every change follows a cycle in which chip select was high.
- R11: During a RAM write, the RAM data output carries the host data byte. The host data output always follows the RAM data input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSelN | input | 1 | Host access select, active low, asynchronous |
| hostWrite | input | 1 | High for a write access, low for a read |
| hostClr | input | 1 | Synchronous single-cycle request to clear the counter |
| hostPage | input | PAGE_W | Upper host address lines (0,1 RAM; 2 high byte; 3 low byte) |
| hostDataIn | input | DATA_W | Byte from the host |
| hostDataOut | output | DATA_W | Byte returned to the host |
| sramAddr | output | ADDR_W | Address to the RAM |
| sramCsN | output | 1 | RAM chip select, active low |
| sramWeN | output | 1 | RAM write enable, active low |
| sramDataOut | output | DATA_W | Byte written to the RAM |
| sramDataIn | input | DATA_W | Byte read from the RAM |

## Verification
The bench checks every RAM access against a model of the counter. A design that stepped on the falling edge of select, or stepped twice for one pulse, would show the wrong address at the start of the next access. The bench also watches the address through every access. If the address moved while chip select was low, the bench would catch a write landing on two locations. A low and high byte load followed by an access checks that the pending low byte is never used on its own. A load of 0xFFFF followed by two accesses exercises the wrap. A clear raised during a RAM access and another during a high-byte load check that the clear is held back until select is released, and that it beats both the step and the load. If either of those were wrong, the next access would land somewhere other than 0x0000.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;
  // strobes from control to datapath, each valid for one clock
  typedef struct packed {
    logic step;    // advance the counter by one
    logic clear;   // force the counter to zero
    logic loadLo;  // capture pending low byte
    logic loadHi;  // load counter from high byte and pending low byte
  } ctrlStrb_t;
endpackage

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PAGE_W  = 2,
  parameter int LO_PAGE = 3,
  parameter int HI_PAGE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSelN,
  input  logic              hostWrite,
  input  logic              hostClr,
  input  logic [PAGE_W-1:0] hostPage,
  input  logic [DATA_W-1:0] hostData,
  output ctrlStrb_t         strb,
  output logic [DATA_W-1:0] capData,
  output logic              sramCsN,
  output logic              sramWeN
);
  localparam logic [PAGE_W-1:0] LoCode = PAGE_W'(LO_PAGE);
  localparam logic [PAGE_W-1:0] HiCode = PAGE_W'(HI_PAGE);

  logic selS1, selS2, selS3;
  logic [PAGE_W-1:0] capPage;
  logic capWr;
  logic clrPend;
  logic riseSeen, isSram, clrReq, applyClr;

  // two-stage synchroniser plus one stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selS1 <= 1'b1;
      selS2 <= 1'b1;
      selS3 <= 1'b1;
    end else begin
      selS1 <= hostSelN;
      selS2 <= selS1;
      selS3 <= selS2;
    end
  end

  // capture the access attributes one stage ahead of the active window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capPage <= '0;
      capWr   <= 1'b0;
      capData <= '0;
    end else if (!selS1) begin
      capPage <= hostPage;
      capWr   <= hostWrite;
      capData <= hostData;
    end
  end

  assign riseSeen = selS2 & ~selS3;
  assign isSram   = (capPage != LoCode) && (capPage != HiCode);
  assign clrReq   = clrPend | hostClr;
  assign applyClr = clrReq & selS2;

  // a clear seen during an active access waits for select release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clrPend <= 1'b0;
    else       clrPend <= clrReq & ~selS2;
  end

  always_comb begin
    strb.clear  = applyClr;
    strb.step   = riseSeen & isSram & ~applyClr;
    strb.loadHi = riseSeen & (capPage == HiCode) & capWr & ~applyClr;
    strb.loadLo = riseSeen & (capPage == LoCode) & capWr;
  end

  assign sramCsN = ~(~selS2 & isSram);
  assign sramWeN = ~(~selS2 & isSram & capWr);

  // R2
  step_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> !strb.step);

  // R4
  clr_defer_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostClr && !selS2) |=> (clrPend || strb.clear));

  // R9
  we_in_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sramWeN |-> !sramCsN);

  // R9
  we_quiet_strb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step || strb.clear || strb.loadHi) |-> sramWeN);

  // R8
  cs_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sramCsN) |-> !selS2);
endmodule

// File: rtl/sram_seq_dp.sv
module sram_seq_dp
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] capData,
  input  logic [DATA_W-1:0] sramDataIn,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] sramDataOut,
  output logic [DATA_W-1:0] hostDataOut
);
  localparam int HI_W = ADDR_W - DATA_W;

  logic [DATA_W-1:0] loShadow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            loShadow <= '0;
    else if (strb.loadLo) loShadow <= capData;
  end

  // clear beats load, load beats step
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            addr <= '0;
    else if (strb.clear)  addr <= '0;
    else if (strb.loadHi) addr <= {capData[HI_W-1:0], loShadow};
    else if (strb.step)   addr <= addr + ADDR_W'(1);
  end

  assign sramDataOut = capData;
  assign hostDataOut = sramDataIn;

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> addr == $past(addr) + ADDR_W'(1));

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> addr == '0);

  // R6
  load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadHi |=> addr == {$past(capData[HI_W-1:0]), $past(loShadow)});

  // R5
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadLo && !strb.clear) |=> addr == $past(addr));
endmodule

// File: rtl/sram_addr_seq.sv
module sram_addr_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int PAGE_W  = 2,
  parameter int LO_PAGE = 3,
  parameter int HI_PAGE = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSelN,
  input  logic              hostWrite,
  input  logic              hostClr,
  input  logic [PAGE_W-1:0] hostPage,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramCsN,
  output logic              sramWeN,
  output logic [DATA_W-1:0] sramDataOut,
  input  logic [DATA_W-1:0] sramDataIn
);
  ctrlStrb_t strb;
  logic [DATA_W-1:0] capData;

  sram_seq_ctrl #(
    .DATA_W(DATA_W), .PAGE_W(PAGE_W), .LO_PAGE(LO_PAGE), .HI_PAGE(HI_PAGE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hostSelN(hostSelN), .hostWrite(hostWrite),
    .hostClr(hostClr), .hostPage(hostPage), .hostData(hostDataIn),
    .strb(strb), .capData(capData), .sramCsN(sramCsN), .sramWeN(sramWeN)
  );

  sram_seq_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .capData(capData),
    .sramDataIn(sramDataIn), .addr(sramAddr),
    .sramDataOut(sramDataOut), .hostDataOut(hostDataOut)
  );

  // R10
  addr_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sramAddr != $past(sramAddr)) |-> $past(sramCsN));
endmodule

// File: tb/sram_addr_seq_bench.sv
`timescale 1ns/1ps
module sram_addr_seq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSelN = 1'b1, hostWrite = 1'b0, hostClr = 1'b0;
  logic [1:0]  hostPage = 2'd0;
  logic [7:0]  hostDataIn = 8'h00;
  logic [7:0]  hostDataOut, sramDataOut, sramDataIn;
  logic [15:0] sramAddr;
  logic sramCsN, sramWeN;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] addr;
    logic        wr;
    logic [7:0]  data;
  } item_t;
  item_t expQ[$];

  logic [15:0] modelAddr = 16'h0000;
  logic [7:0]  modelLo = 8'h00;

  always #2.5 clk = ~clk;

  // RAM read data is a function of the address
  assign sramDataIn = sramAddr[7:0] ^ sramAddr[15:8] ^ 8'h5A;

  sram_addr_seq u_sram_addr_seq (
    .clk(clk), .rstN(rstN), .hostSelN(hostSelN), .hostWrite(hostWrite),
    .hostClr(hostClr), .hostPage(hostPage), .hostDataIn(hostDataIn),
    .hostDataOut(hostDataOut), .sramAddr(sramAddr), .sramCsN(sramCsN),
    .sramWeN(sramWeN), .sramDataOut(sramDataOut), .sramDataIn(sramDataIn)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one host access, expected RAM access pushed to the queue
  task automatic access(input logic [1:0] page, input logic wr,
                        input logic [7:0] data, input bit clrMid);
    item_t it;
    if (page < 2) begin
      it.addr = modelAddr; it.wr = wr; it.data = data;
      expQ.push_back(it);
    end
    @(negedge clk);
    hostPage = page; hostWrite = wr; hostDataIn = data; hostSelN = 1'b0;
    repeat (3) @(negedge clk);
    if (clrMid) hostClr = 1'b1;
    @(negedge clk);
    hostClr = 1'b0;
    @(negedge clk);
    hostSelN = 1'b1;
    repeat (6) @(negedge clk);
    if (page == 2'd3 && wr) modelLo = data;
    if (clrMid)                    modelAddr = 16'h0000;
    else if (page < 2)             modelAddr = modelAddr + 16'h0001;
    else if (page == 2'd2 && wr)   modelAddr = {data, modelLo};
  endtask

  task automatic clearIdle();
    @(negedge clk);
    hostClr = 1'b1;
    @(negedge clk);
    hostClr = 1'b0;
    repeat (2) @(negedge clk);
    modelAddr = 16'h0000;
  endtask

  // monitor: compare each RAM access with the queue head
  item_t cur;
  bit inAcc = 0, moved = 0, weBad = 0, dataBad = 0;
  logic prevCs = 1'b1;
  always @(negedge clk) begin
    if (rstN) begin
      if (!sramCsN && prevCs) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected select", {16'h0, sramAddr}, 32'hFFFFFFFF);
        end else begin
          cur = expQ.pop_front();
          inAcc = 1; moved = 0; weBad = 0; dataBad = 0;
          // R2/R3/R4/R6 address of the access
          check(sramAddr == cur.addr, "R2/R3/R4/R6 address", {16'h0, sramAddr},
                {16'h0, cur.addr});
          if (!cur.wr)
            check(hostDataOut == (cur.addr[7:0] ^ cur.addr[15:8] ^ 8'h5A),
                  "R11 read data", {24'h0, hostDataOut},
                  {24'h0, cur.addr[7:0] ^ cur.addr[15:8] ^ 8'h5A});
        end
      end
      if (!sramCsN && inAcc) begin
        if (sramAddr != cur.addr) moved = 1;
        if (sramWeN != !cur.wr) weBad = 1;
        if (cur.wr && sramDataOut != cur.data) dataBad = 1;
      end
      if (sramCsN && !prevCs && inAcc) begin
        inAcc = 0;
        check(!moved, "R10 address stable in access", {31'h0, moved}, 32'h0);
        check(!weBad, "R9 write enable", {31'h0, weBad}, 32'h0);
        if (cur.wr) check(!dataBad, "R11 write data", {31'h0, dataBad}, 32'h0);
      end
      prevCs = sramCsN;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(sramAddr == 16'h0, "R1 reset address", {16'h0, sramAddr}, 32'h0);
    check(sramCsN && sramWeN, "R1 reset strobes", {30'h0, sramCsN, sramWeN}, 32'h3);
    // R2 consecutive writes and reads
    access(2'd0, 1'b1, 8'hA5, 0);
    access(2'd0, 1'b1, 8'h3C, 0);
    access(2'd1, 1'b1, 8'h81, 0);
    access(2'd1, 1'b0, 8'h00, 0);
    // R5 low byte only, next access unchanged
    access(2'd3, 1'b1, 8'h34, 0);
    access(2'd0, 1'b0, 8'h00, 0);
    // R6 high byte load
    access(2'd2, 1'b1, 8'h12, 0);
    access(2'd0, 1'b0, 8'h00, 0);
    access(2'd0, 1'b1, 8'h77, 0);
    // R7 register read has no effect
    access(2'd2, 1'b0, 8'h99, 0);
    access(2'd3, 1'b0, 8'h55, 0);
    access(2'd1, 1'b0, 8'h00, 0);
    // R4 clear while idle
    clearIdle();
    access(2'd0, 1'b0, 8'h00, 0);
    // R4 clear during an access replaces its step
    access(2'd0, 1'b1, 8'hC3, 1);
    access(2'd0, 1'b0, 8'h00, 0);
    // R3 wrap from the top
    access(2'd3, 1'b1, 8'hFF, 0);
    access(2'd2, 1'b1, 8'hFF, 0);
    access(2'd0, 1'b1, 8'h11, 0);
    access(2'd0, 1'b0, 8'h00, 0);
    // R4 clear beats a high-byte load
    access(2'd2, 1'b1, 8'h77, 1);
    access(2'd1, 1'b0, 8'h00, 0);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R8 missing accesses", expQ.size(), 32'h0);
    check(sramAddr == modelAddr, "R2 final address", {16'h0, sramAddr},
          {16'h0, modelAddr});
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule